// File: doc/BRIEF.md
# Monotonic Zone Usage Counter Bank

This block holds one usage counter for each key zone. Each counter only moves upward. When a zone's key is used, a strobe with the zone index advances that zone's counter by one, if counting is enabled for that zone. Software may also write a counter directly. The write is accepted only when it moves the counter forward or leaves it where it is.

Each counter is kept as two copies. The primary copy takes every update. The shadow copy follows it one clock later. While the two copies differ, the zone's mismatch output is high. An update cut short by a power loss would therefore leave the mismatch visible.

Counters stop at a ceiling value. A zone whose retire option is set gets its key permanently disabled once its counter reaches the ceiling. Only a full reset clears the disable. Zones can also be locked one at a time against direct writes. Key-use counting continues on a locked zone.

Top module: `zone_usage_ctr_bank`

## Requirements
- R1: After a synchronous active-high reset:
  - every counter copy reads zero;
  - `key_disabled` and `copy_mismatch` are all zero;
  - no zone is locked;
  - `wr_ok` and `wr_rej` are low.
- R2: A key use (`use_valid` high, zone `use_zone`) adds one to that zone's counter at the clock edge only when `inc_enable[use_zone]` is 1. When that bit is 0, the counter does not change.
- R3: A counter that already equals `CNT_MAX` stays at `CNT_MAX` on further key uses. No counter ever exceeds `CNT_MAX`.
- R4: A direct write (`wr_en` high) is accepted when all of the following hold:
  - `wr_data` is at least the zone's current count;
  - `wr_data` is at most `CNT_MAX`;
  - the zone is not locked;
  - no key use hits the same zone in that cycle.
  
  An accepted write loads `wr_data` at the edge and raises `wr_ok` for one cycle after that edge.
- R5: Any other write leaves the counter unchanged and raises `wr_rej` for one cycle after the edge. `wr_ok` and `wr_rej` are never high together.
- R6: A pulse on `lock_en` locks zone `lock_zone` from the next edge onward. Writes to a locked zone are rejected, while key uses still advance it.
- R7: The shadow copy takes the primary copy's value one cycle after it changes. `copy_mismatch[z]` is high exactly while the two copies of zone z differ, which is the single cycle after a value change.
- R8: When `retire_enable[z]` is 1 and zone z's count equals `CNT_MAX`, `key_disabled[z]` rises at the next edge. It then stays high until reset.
- R9: `rd_count` shows the primary copy of zone `rd_zone` in the same cycle, with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| use_valid | input | 1 | Key-use strobe |
| use_zone | input | ZW | Zone whose key was used |
| inc_enable | input | NUM_ZONES | Per-zone count-on-use enable |
| retire_enable | input | NUM_ZONES | Per-zone disable-at-ceiling option |
| wr_en | input | 1 | Direct counter write request |
| wr_zone | input | ZW | Zone targeted by the write |
| wr_data | input | CNT_W | Requested new count |
| lock_en | input | 1 | Lock request |
| lock_zone | input | ZW | Zone to lock |
| rd_zone | input | ZW | Zone selected for reading |
| rd_count | output | CNT_W | Primary copy of the selected zone |
| wr_ok | output | 1 | Previous-cycle write accepted |
| wr_rej | output | 1 | Previous-cycle write rejected |
| key_disabled | output | NUM_ZONES | Sticky per-zone key retirement |
| copy_mismatch | output | NUM_ZONES | Primary and shadow copies differ |

## Verification
The bench keeps 16 zones and 32-bit counters but lowers `CNT_MAX` to 40. With that ceiling, saturation, retirement and the write-above-ceiling rejection are reached within a few dozen key uses rather than two million. A reference model in the bench tracks both copies, locks and retirements. It compares all outputs every cycle, under directed cases and then a long pseudo-random mix of uses, writes and locks that often collide on one zone.

// File: rtl/zctr_pkg.sv
package zctr_pkg;

    localparam int ZCTR_ZONES_DEF = 16;
    localparam int ZCTR_CNT_W_DEF = 32;
    localparam int ZCTR_MAX_DEF   = 2097151;

    typedef enum logic [1:0] {
        RESP_IDLE   = 2'd0,
        RESP_ACCEPT = 2'd1,
        RESP_REJECT = 2'd2
    } wr_resp_e;

    // saturating advance toward the ceiling
    function automatic logic [63:0] sat_step(input logic [63:0] cur, input logic [63:0] ceil);
        return (cur >= ceil) ? ceil : cur + 64'd1;
    endfunction

    // forward-only write rule
    function automatic logic fwd_ok(input logic [63:0] cur, input logic [63:0] req,
                                    input logic [63:0] ceil);
        return (req >= cur) && (req <= ceil);
    endfunction

endpackage

// File: rtl/zctr_cell.sv
module zctr_cell
    import zctr_pkg::*;
#(
    parameter int CNT_W   = ZCTR_CNT_W_DEF,
    parameter int CNT_MAX = ZCTR_MAX_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             use_sel,
    input  logic             inc_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             lock_set,
    input  logic             retire_en,
    output logic [CNT_W-1:0] cnt_a,
    output logic             mismatch,
    output logic             key_dis,
    output logic             locked,
    output logic             wr_take
);
    localparam logic [CNT_W-1:0] CEIL = CNT_W'(CNT_MAX);

    logic [CNT_W-1:0] cnt_b;
    logic [CNT_W-1:0] a_next;
    logic             bump;

    always_comb begin
        bump    = use_sel && inc_en;
        wr_take = wr_sel && !locked && !use_sel &&
                  fwd_ok(64'(cnt_a), 64'(wr_data), 64'(CEIL));
        a_next  = cnt_a;
        if (bump)
            a_next = CNT_W'(sat_step(64'(cnt_a), 64'(CEIL)));
        else if (wr_take)
            a_next = wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_a   <= '0;
            cnt_b   <= '0;
            locked  <= 1'b0;
            key_dis <= 1'b0;
        end else begin
            cnt_a   <= a_next;
            cnt_b   <= cnt_a;
            locked  <= locked | lock_set;
            key_dis <= key_dis | (retire_en && (cnt_a == CEIL));
        end
    end

    assign mismatch = (cnt_a != cnt_b);

    assert_monotonic_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cnt_a >= $past(cnt_a)));

    assert_ceiling_R3: assert property (@(posedge clk) disable iff (rst)
        cnt_a <= CEIL);

    assert_mismatch_cause_R7: assert property (@(posedge clk) disable iff (rst)
        (cnt_a != cnt_b) |-> (cnt_a != $past(cnt_a)));

    assert_sticky_retire_R8: assert property (@(posedge clk) disable iff (rst)
        key_dis |=> key_dis);

    assert_lock_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (locked && wr_sel && !use_sel) |=> $stable(cnt_a));

endmodule

// File: rtl/zctr_resp.sv
module zctr_resp
    import zctr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic taken,
    output logic wr_ok,
    output logic wr_rej
);
    wr_resp_e resp_q;

    always_ff @(posedge clk) begin
        if (rst)
            resp_q <= RESP_IDLE;
        else if (!wr_en)
            resp_q <= RESP_IDLE;
        else
            resp_q <= taken ? RESP_ACCEPT : RESP_REJECT;
    end

    assign wr_ok  = (resp_q == RESP_ACCEPT);
    assign wr_rej = (resp_q == RESP_REJECT);

    assert_resp_excl_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_ok, wr_rej}));

    assert_resp_follows_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (wr_ok || wr_rej));

endmodule

// File: rtl/zone_usage_ctr_bank.sv
module zone_usage_ctr_bank
    import zctr_pkg::*;
#(
    parameter int NUM_ZONES = ZCTR_ZONES_DEF,
    parameter int CNT_W     = ZCTR_CNT_W_DEF,
    parameter int CNT_MAX   = ZCTR_MAX_DEF,
    localparam int ZW       = (NUM_ZONES > 1) ? $clog2(NUM_ZONES) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 use_valid,
    input  logic [ZW-1:0]        use_zone,
    input  logic [NUM_ZONES-1:0] inc_enable,
    input  logic [NUM_ZONES-1:0] retire_enable,
    input  logic                 wr_en,
    input  logic [ZW-1:0]        wr_zone,
    input  logic [CNT_W-1:0]     wr_data,
    input  logic                 lock_en,
    input  logic [ZW-1:0]        lock_zone,
    input  logic [ZW-1:0]        rd_zone,
    output logic [CNT_W-1:0]     rd_count,
    output logic                 wr_ok,
    output logic                 wr_rej,
    output logic [NUM_ZONES-1:0] key_disabled,
    output logic [NUM_ZONES-1:0] copy_mismatch
);
    logic [CNT_W-1:0]     cnt_arr [NUM_ZONES];
    logic [NUM_ZONES-1:0] take_vec;
    logic [NUM_ZONES-1:0] lock_vec;

    for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zone
        zctr_cell #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) u_cell (
            .clk       (clk),
            .rst       (rst),
            .use_sel   (use_valid && (use_zone == ZW'(z))),
            .inc_en    (inc_enable[z]),
            .wr_sel    (wr_en && (wr_zone == ZW'(z))),
            .wr_data   (wr_data),
            .lock_set  (lock_en && (lock_zone == ZW'(z))),
            .retire_en (retire_enable[z]),
            .cnt_a     (cnt_arr[z]),
            .mismatch  (copy_mismatch[z]),
            .key_dis   (key_disabled[z]),
            .locked    (lock_vec[z]),
            .wr_take   (take_vec[z])
        );
    end

    zctr_resp u_resp (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .taken  (|take_vec),
        .wr_ok  (wr_ok),
        .wr_rej (wr_rej)
    );

    assign rd_count = cnt_arr[rd_zone];

    assert_locked_rejects_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && lock_vec[wr_zone]) |=> wr_rej);

    assert_single_take_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(take_vec));

endmodule

// File: tb/tb_zone_usage_ctr_bank.sv
module tb_zone_usage_ctr_bank;
    localparam int NZ   = 16;
    localparam int CW   = 32;
    localparam int CMAX = 40;
    localparam int ZW   = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          use_valid = 0;
    logic [ZW-1:0] use_zone = 0;
    logic [NZ-1:0] inc_enable = 16'h00FF;
    logic [NZ-1:0] retire_enable = 16'h0003;
    logic          wr_en = 0;
    logic [ZW-1:0] wr_zone = 0;
    logic [CW-1:0] wr_data = 0;
    logic          lock_en = 0;
    logic [ZW-1:0] lock_zone = 0;
    logic [ZW-1:0] rd_zone = 0;
    logic [CW-1:0] rd_count;
    logic          wr_ok, wr_rej;
    logic [NZ-1:0] key_disabled, copy_mismatch;

    zone_usage_ctr_bank #(.NUM_ZONES(NZ), .CNT_W(CW), .CNT_MAX(CMAX)) dut (
        .clk(clk), .rst(rst), .use_valid(use_valid), .use_zone(use_zone),
        .inc_enable(inc_enable), .retire_enable(retire_enable),
        .wr_en(wr_en), .wr_zone(wr_zone), .wr_data(wr_data),
        .lock_en(lock_en), .lock_zone(lock_zone), .rd_zone(rd_zone),
        .rd_count(rd_count), .wr_ok(wr_ok), .wr_rej(wr_rej),
        .key_disabled(key_disabled), .copy_mismatch(copy_mismatch)
    );

    always #5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // reference model
    longint ma [NZ];
    longint mb [NZ];
    bit     mlk [NZ];
    bit     mdis [NZ];
    bit     e_ok, e_rej;

    task automatic chk(input string req, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int z = 0; z < NZ; z++) begin
            ma[z] = 0; mb[z] = 0; mlk[z] = 0; mdis[z] = 0;
        end
        e_ok = 0; e_rej = 0;
    endtask

    task automatic model_step();
        longint oa [NZ];
        bit     olk [NZ];
        bit     acc;
        for (int z = 0; z < NZ; z++) begin
            oa[z] = ma[z]; olk[z] = mlk[z];
        end
        acc = !olk[wr_zone] && (longint'(wr_data) >= oa[wr_zone]) &&
              (longint'(wr_data) <= CMAX) && !(use_valid && use_zone == wr_zone);
        for (int z = 0; z < NZ; z++) begin
            mb[z] = oa[z];
            if (lock_en && lock_zone == z) mlk[z] = 1;
            if (retire_enable[z] && oa[z] == CMAX) mdis[z] = 1;
            if (use_valid && use_zone == z && inc_enable[z])
                ma[z] = (oa[z] >= CMAX) ? CMAX : oa[z] + 1;
            else if (wr_en && wr_zone == z && acc)
                ma[z] = longint'(wr_data);
        end
        e_ok  = wr_en && acc;
        e_rej = wr_en && !acc;
    endtask

    task automatic compare(input string req);
        longint mm = 0, kd = 0;
        for (int z = 0; z < NZ; z++) begin
            if (ma[z] != mb[z]) mm |= (64'd1 << z);
            if (mdis[z])        kd |= (64'd1 << z);
        end
        chk({req, " rd_count R9"}, rd_count, ma[rd_zone]);
        chk("R4 wr_ok", wr_ok, e_ok);
        chk("R5 wr_rej", wr_rej, e_rej);
        chk("R7 copy_mismatch", copy_mismatch, mm);
        chk("R8 key_disabled", key_disabled, kd);
    endtask

    // one cycle: inputs set now, edge, model, compare mid-cycle
    task automatic step(input string req, input bit uv, input int uz,
                        input bit wv, input int wz, input longint wd,
                        input bit lv, input int lz, input int rz);
        use_valid = uv; use_zone = ZW'(uz);
        wr_en = wv; wr_zone = ZW'(wz); wr_data = CW'(wd);
        lock_en = lv; lock_zone = ZW'(lz);
        @(posedge clk);
        if (rst) model_reset(); else model_step();
        @(negedge clk);
        rd_zone = ZW'(rz);
        #1;
        compare(req);
        use_valid = 0; wr_en = 0; lock_en = 0;
    endtask

    task automatic idle(input string req, input int rz);
        step(req, 0, 0, 0, 0, 0, 0, 0, rz);
    endtask

    initial begin
        model_reset();
        idle("R1", 0);
        idle("R1", 5);
        rst = 0;
        idle("R1", 0);
        // R2: counting with and without enable
        for (int i = 0; i < 5; i++) step("R2 use z0", 1, 0, 0, 0, 0, 0, 0, 0);
        idle("R7", 0);
        step("R2 disabled z9", 1, 9, 0, 0, 0, 0, 0, 9);
        step("R2 disabled z9", 1, 9, 0, 0, 0, 0, 0, 9);
        // R4/R5 write rules
        step("R4 fwd write", 0, 0, 1, 2, 30, 0, 0, 2);
        step("R5 backward write", 0, 0, 1, 2, 20, 0, 0, 2);
        step("R4 equal write", 0, 0, 1, 2, 30, 0, 0, 2);
        step("R5 above ceiling", 0, 0, 1, 2, CMAX + 1, 0, 0, 2);
        step("R5 collide", 1, 4, 1, 4, 10, 0, 0, 4);
        // R6 lock
        step("R6 lock z3", 0, 0, 0, 0, 0, 1, 3, 3);
        step("R6 locked write", 0, 0, 1, 3, 10, 0, 0, 3);
        step("R6 locked use", 1, 3, 0, 0, 0, 0, 0, 3);
        // R3/R8 ceiling and retirement
        step("R4 z0 near ceil", 0, 0, 1, 0, CMAX - 2, 0, 0, 0);
        for (int i = 0; i < 4; i++) step("R3 saturate z0", 1, 0, 0, 0, 0, 0, 0, 0);
        step("R8 z1 at ceil", 0, 0, 1, 1, CMAX, 0, 0, 1);
        idle("R8", 1);
        step("R8 z2 at ceil no retire", 0, 0, 1, 2, CMAX, 0, 0, 2);
        idle("R8", 2);
        retire_enable[2] = 1'b1;
        idle("R8 late enable", 2);
        idle("R8", 2);
        // mixed traffic
        for (int i = 0; i < 600; i++) begin
            int r = $urandom;
            if (i % 97 == 50) inc_enable = NZ'($urandom);
            if (i % 131 == 70) retire_enable = NZ'($urandom);
            step("R2 mix", r[0], $urandom_range(0, NZ - 1), r[1] & r[2],
                 $urandom_range(0, NZ - 1), $urandom_range(0, CMAX + 3),
                 (r[7:3] == 0), $urandom_range(0, NZ - 1), $urandom_range(0, NZ - 1));
        end
        // reset clears sticky state
        rst = 1;
        idle("R1 reset", 0);
        rst = 0;
        idle("R1", 1);
        idle("R1", 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule